// File: doc/BRIEF.md
# Multi-mode operand address sequencer

This block sits between instruction decode and the ALU of a register-memory machine. It turns an operand specifier into an operand value. The specifier is a mode code, a base and an index register number, a constant field, an absolute address field and an operand size code. For the modes that touch memory, the block forms the effective address and issues one or two reads over a request/grant, response-valid handshake. It returns the fetched word on `operand` with a one-cycle `done` pulse.

Register contents come from two combinational register-file read ports. The block samples them only in the cycle it accepts `start`. The post-increment and pre-decrement modes update the base register through a single write port. That write happens once per instruction, in the cycle of `done`. Mode codes with no meaning and the unused size code finish at once with `err` set, and they leave memory and registers alone. While an instruction is in flight, the block ignores `start`.

Top module: `opnd_addr_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `done`, `err`, `mem_req` and `rf_we` are all 0.
- R2: Register mode (code 0) sets `done` in the cycle after `start`, with `operand` equal to the base register contents, `err` 0 and no memory request.
- R3: Immediate mode (code 1) sets `done` in the cycle after `start`, with `operand` equal to the zero-extended constant field and no memory request.
- R4: Single-read modes issue exactly one read, and `operand` is the returned word. The read addresses are: base+constant for code 2, base for code 3, base+index for code 4, and the absolute field for code 5.
- R5: Pointer-chasing mode (code 6) first reads at the base register value. It then reads at the word that first read returned, and `operand` is the word from the second read.
- R6: Post-increment mode (code 7) reads at the base value. In the cycle of `done` it writes base+d back to the base register. The step d is 1, 2 or 4 for size codes 0, 1 and 2.
- R7: Pre-decrement mode (code 8) reads at base−d and writes base−d back to the base register in the cycle of `done`.
- R8: Scaled mode (code 9) reads at constant + base + (index shifted left by the size code).
- R9: `mem_req` stays high with `mem_addr` unchanged until a cycle with `mem_gnt`. Any number of cycles may separate the request, the grant and `mem_rvalid`.
- R10: A mode code of 10 to 15, or size code 3, gives `done` and `err` in the cycle after `start`. Such an instruction has `operand` 0, makes no memory request and does no register write.
- R11: A `start` that arrives while an instruction is in flight is ignored. No extra `done` and no extra access follow from it.
- R12: The base-register write happens exactly once per post-increment or pre-decrement instruction, and never for any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a new operand specifier (only when idle) |
| mode | input | 4 | Addressing mode code |
| size_code | input | 2 | Operand size: 0=1 byte, 1=2, 2=4, 3 illegal |
| base_sel | input | RIDX_W | Base register number |
| index_sel | input | RIDX_W | Index register number |
| const_fld | input | ADDR_W | Displacement or immediate constant |
| abs_fld | input | ADDR_W | Absolute address |
| rf_a_idx | output | RIDX_W | Register read port A index (base) |
| rf_a_data | input | DATA_W | Register read port A data, combinational |
| rf_b_idx | output | RIDX_W | Register read port B index (index) |
| rf_b_data | input | DATA_W | Register read port B data, combinational |
| rf_we | output | 1 | Base register write enable |
| rf_widx | output | RIDX_W | Write register number |
| rf_wdata | output | DATA_W | Write data (updated base) |
| mem_req | output | 1 | Memory read request, held until granted |
| mem_addr | output | ADDR_W | Memory read address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read response data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal specifier, valid with done |
| operand | output | DATA_W | Fetched operand, valid with done |

## Verification
A corrupted latched address shows up on `mem_addr` in the very first request cycle, and the bench logs every granted address against its own computed list. A wrong pointer-phase or write-back flag shows up as the wrong number of granted reads, or a missing or extra `rf_we`, by the `done` of the same instruction. The bench also reads the register model back on later instructions. A state machine that leaves idle wrongly shows up either as `done` arriving in the wrong cycle for the single-cycle modes, or as an extra `done` in the quiet cycles after an instruction that had a `start` injected during it.

// File: rtl/opnd_pkg.sv
// Shared codes and types for the operand address sequencer.
// Assumes mode codes 0..9 are defined and 10..15 are illegal.
package opnd_pkg;
    localparam logic [3:0] MD_REG   = 4'd0;
    localparam logic [3:0] MD_IMM   = 4'd1;
    localparam logic [3:0] MD_DISP  = 4'd2;
    localparam logic [3:0] MD_RIND  = 4'd3;
    localparam logic [3:0] MD_INDEX = 4'd4;
    localparam logic [3:0] MD_ABS   = 4'd5;
    localparam logic [3:0] MD_PTR   = 4'd6;
    localparam logic [3:0] MD_POSTI = 4'd7;
    localparam logic [3:0] MD_PRED  = 4'd8;
    localparam logic [3:0] MD_SCALE = 4'd9;
    localparam logic [3:0] MD_LAST  = MD_SCALE;

    localparam logic [1:0] SZ_BAD = 2'd3;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_WAIT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic legal;
        logic uses_mem;
        logic two_reads;
        logic writes_base;
        logic take_const;
    } mode_info_t;
endpackage

// File: rtl/opnd_mode_dec.sv
// Classifies a mode/size pair into the control flags the sequencer needs.
// Purely combinational; assumes inputs are stable in the start cycle.
module opnd_mode_dec
    import opnd_pkg::*;
(
    input  logic [3:0] mode,
    input  logic [1:0] size_code,
    output mode_info_t info
);
    // Derive each flag from the mode code.
    always_comb begin
        info.legal       = (mode <= MD_LAST) && (size_code != SZ_BAD);
        info.uses_mem    = (mode >= MD_DISP) && (mode <= MD_LAST);
        info.two_reads   = (mode == MD_PTR);
        info.writes_base = (mode == MD_POSTI) || (mode == MD_PRED);
        info.take_const  = (mode == MD_IMM);
    end
endmodule

// File: rtl/opnd_addr_gen.sv
// Forms the first memory address and the updated base value for a mode.
// Assumes size_code is 0..2; step d = 1 << size_code bytes.
module opnd_addr_gen
    import opnd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [3:0]        mode,
    input  logic [1:0]        size_code,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [ADDR_W-1:0] const_val,
    input  logic [ADDR_W-1:0] abs_val,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] new_base
);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] scaled_idx;

    // Step size and scaled index both come from the size code.
    always_comb begin
        step       = ADDR_W'(1) << size_code;
        scaled_idx = index_val << size_code;
    end

    // Select the address of the first read per mode.
    always_comb begin
        case (mode)
            MD_DISP:  first_addr = const_val + base_val;
            MD_RIND,
            MD_PTR,
            MD_POSTI: first_addr = base_val;
            MD_INDEX: first_addr = base_val + index_val;
            MD_ABS:   first_addr = abs_val;
            MD_PRED:  first_addr = base_val - step;
            MD_SCALE: first_addr = const_val + base_val + scaled_idx;
            default:  first_addr = '0;
        endcase
    end

    // Updated base for the two side-effect modes.
    always_comb begin
        new_base = (mode == MD_PRED) ? (base_val - step) : (base_val + step);
    end
endmodule

// File: rtl/opnd_addr_seq.sv
// Operand address sequencer: accepts a specifier on start, reads registers
// combinationally in that cycle, issues zero, one or two memory reads and
// pulses done with the operand. Assumes DATA_W >= ADDR_W, a response arrives
// only after the grant cycle, and the register ports are combinational.
module opnd_addr_seq
    import opnd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NREGS  = 32,
    localparam int RIDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [1:0]        size_code,
    input  logic [RIDX_W-1:0] base_sel,
    input  logic [RIDX_W-1:0] index_sel,
    input  logic [ADDR_W-1:0] const_fld,
    input  logic [ADDR_W-1:0] abs_fld,
    output logic [RIDX_W-1:0] rf_a_idx,
    input  logic [DATA_W-1:0] rf_a_data,
    output logic [RIDX_W-1:0] rf_b_idx,
    input  logic [DATA_W-1:0] rf_b_data,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_widx,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] operand
);
    seq_state_t        state_q;
    mode_info_t        info;
    logic [ADDR_W-1:0] gen_addr;
    logic [ADDR_W-1:0] gen_base;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wb_q;
    logic [RIDX_W-1:0] base_idx_q;
    logic              ptr_pend_q;
    logic              wb_en_q;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] operand_q;
    logic              rf_we_q;
    logic [DATA_W-1:0] rf_wdata_q;
    logic              seq_idle;

    opnd_mode_dec u_dec (
        .mode      (mode),
        .size_code (size_code),
        .info      (info)
    );

    opnd_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .mode       (mode),
        .size_code  (size_code),
        .base_val   (rf_a_data[ADDR_W-1:0]),
        .index_val  (rf_b_data[ADDR_W-1:0]),
        .const_val  (const_fld),
        .abs_val    (abs_fld),
        .first_addr (gen_addr),
        .new_base   (gen_base)
    );

    // Register read ports follow the live specifier; used only at start.
    always_comb begin
        rf_a_idx = base_sel;
        rf_b_idx = index_sel;
        seq_idle = (state_q == S_IDLE);
    end

    // Sequencer state, latched request fields and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            addr_q     <= '0;
            wb_q       <= '0;
            base_idx_q <= '0;
            ptr_pend_q <= 1'b0;
            wb_en_q    <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            operand_q  <= '0;
            rf_we_q    <= 1'b0;
            rf_wdata_q <= '0;
        end else begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rf_we_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        base_idx_q <= base_sel;
                        if (!info.legal) begin
                            done_q    <= 1'b1;
                            err_q     <= 1'b1;
                            operand_q <= '0;
                        end else if (!info.uses_mem) begin
                            done_q    <= 1'b1;
                            operand_q <= info.take_const ? DATA_W'(const_fld) : rf_a_data;
                        end else begin
                            addr_q     <= gen_addr;
                            wb_q       <= gen_base;
                            wb_en_q    <= info.writes_base;
                            ptr_pend_q <= info.two_reads;
                            state_q    <= S_REQ;
                        end
                    end
                end
                S_REQ: begin
                    if (mem_gnt) begin
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (mem_rvalid) begin
                        if (ptr_pend_q) begin
                            ptr_pend_q <= 1'b0;
                            addr_q     <= mem_rdata[ADDR_W-1:0];
                            state_q    <= S_REQ;
                        end else begin
                            done_q     <= 1'b1;
                            operand_q  <= mem_rdata;
                            rf_we_q    <= wb_en_q;
                            rf_wdata_q <= DATA_W'(wb_q);
                            state_q    <= S_IDLE;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Drive outputs from the registered state.
    always_comb begin
        mem_req  = (state_q == S_REQ);
        mem_addr = addr_q;
        done     = done_q;
        err      = err_q;
        operand  = operand_q;
        rf_we    = rf_we_q;
        rf_widx  = base_idx_q;
        rf_wdata = rf_wdata_q;
    end
endmodule

// File: rtl/opnd_addr_seq_chk.sv
// Protocol and timing checks for the operand address sequencer, bound in.
module opnd_addr_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        mode,
    input logic [1:0]        size_code,
    input logic              idle,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rf_we,
    input logic              done,
    input logic              err
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R9

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req); // R11

    AST_REG_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && mode == 4'd0 && size_code != 2'd3) |=> (done && !err && !mem_req)); // R2

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && (mode > 4'd9 || size_code == 2'd3)) |=> (done && err && !mem_req && !rf_we)); // R10

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R10

    AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (done && !err)); // R12
endmodule

bind opnd_addr_seq opnd_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .size_code (size_code),
    .idle      (seq_idle),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .rf_we     (rf_we),
    .done      (done),
    .err       (err)
);

// File: tb/opnd_addr_seq_tb.sv
`timescale 1ns/1ps
// Self-checking bench: register file and memory models, directed corners
// and seeded random specifiers checked against computed expectations.
module opnd_addr_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size_code = '0;
    logic [4:0]  base_sel = '0, index_sel = '0;
    logic [31:0] const_fld = '0, abs_fld = '0;
    logic [4:0]  rf_a_idx, rf_b_idx, rf_widx;
    logic [31:0] rf_a_data, rf_b_data, rf_wdata;
    logic        rf_we, mem_req, done, err;
    logic [31:0] mem_addr, operand;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] regs [32];
    logic [31:0] acc_log [4];
    int          acc_n = 0, wb_n = 0;
    logic [4:0]  wb_idx_seen;
    logic [31:0] wb_val_seen;
    int          max_lat = 3;
    int          checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    assign rf_a_data = regs[rf_a_idx];
    assign rf_b_data = regs[rf_b_idx];

    opnd_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size_code(size_code),
        .base_sel(base_sel), .index_sel(index_sel), .const_fld(const_fld), .abs_fld(abs_fld),
        .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data), .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
        .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .err(err), .operand(operand)
    );

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return {a[7:0], a[31:8]} ^ 32'h6c3b_91e5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Register write port model: apply and log writes.
    initial begin
        forever begin
            @(negedge clk);
            if (rf_we) begin
                regs[rf_widx] = rf_wdata;
                wb_idx_seen = rf_widx;
                wb_val_seen = rf_wdata;
                wb_n++;
            end
        end
    end

    // Memory model: random grant delay and response latency.
    initial begin
        bit          pend = 0;
        int          dly = 0;
        int          gw = -1;
        logic [31:0] pa = '0;
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0;
            mem_rvalid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = mem_fn(pa);
                    pend = 0;
                end else dly--;
            end else if (mem_req) begin
                if (gw < 0) gw = int'($urandom % (max_lat + 1));
                if (gw == 0) begin
                    mem_gnt = 1'b1;
                    pa = mem_addr;
                    if (acc_n < 4) acc_log[acc_n] = mem_addr;
                    acc_n++;
                    pend = 1;
                    dly = int'($urandom % (max_lat + 1));
                    gw = -1;
                end else gw--;
            end
        end
    end

    task automatic run_instr(input logic [3:0] md, input logic [1:0] sz, input logic [4:0] bs,
                             input logic [4:0] ix, input logic [31:0] cst, input logic [31:0] ab,
                             input bit inject, input string tag);
        logic [31:0] bv, iv, d, a0, a1, op, wbv;
        int          n_exp, cyc;
        bit          legal, memm, wbx;
        bv = regs[bs]; iv = regs[ix]; d = 32'd1 << sz;
        legal = (md <= 4'd9) && (sz != 2'd3);
        memm  = legal && md >= 4'd2;
        wbx   = legal && (md == 4'd7 || md == 4'd8);
        n_exp = !memm ? 0 : (md == 4'd6 ? 2 : 1);
        a1 = '0; wbv = '0;
        case (md)
            4'd2: a0 = cst + bv;
            4'd4: a0 = bv + iv;
            4'd5: a0 = ab;
            4'd8: a0 = bv - d;
            4'd9: a0 = cst + bv + (iv << sz);
            default: a0 = bv;
        endcase
        if (md == 4'd6) a1 = mem_fn(a0);
        if (!legal) op = '0;
        else if (md == 4'd0) op = bv;
        else if (md == 4'd1) op = cst;
        else op = mem_fn(md == 4'd6 ? a1 : a0);
        wbv = (md == 4'd8) ? bv - d : bv + d;

        @(negedge clk); #1;
        acc_n = 0; wb_n = 0;
        start = 1'b1; mode = md; size_code = sz; base_sel = bs; index_sel = ix;
        const_fld = cst; abs_fld = ab;
        @(negedge clk); #1;
        start = inject; mode = inject ? 4'd0 : 4'($urandom);
        size_code = 2'($urandom); base_sel = 5'($urandom); index_sel = 5'($urandom);
        const_fld = $urandom; abs_fld = $urandom;
        if (!memm) chk(done === 1'b1, {tag, " R2/R3/R10 one-cycle done"}, 32'(done), 1);
        else       chk(done === 1'b0, {tag, " R9 no early done"}, 32'(done), 0);
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk); #1;
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        chk(cyc < 400, {tag, " R9 completion"}, cyc, 0);
        chk(err === !legal, {tag, " R10 err flag"}, 32'(err), 32'(!legal));
        chk(operand === op, {tag, " R4/R5 operand"}, operand, op);
        chk(acc_n == n_exp, {tag, " R10 access count"}, acc_n, n_exp);
        if (n_exp >= 1) chk(acc_log[0] === a0, {tag, " R4/R8 first address"}, acc_log[0], a0);
        if (n_exp == 2) chk(acc_log[1] === a1, {tag, " R5 pointer address"}, acc_log[1], a1);
        chk(wb_n == (wbx ? 1 : 0), {tag, " R12 write count"}, wb_n, wbx ? 1 : 0);
        if (wbx && wb_n == 1) begin
            chk(wb_idx_seen === bs, {tag, " R6/R7 write index"}, 32'(wb_idx_seen), 32'(bs));
            chk(wb_val_seen === wbv, {tag, " R6/R7 written base"}, wb_val_seen, wbv);
        end
        if (inject) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); #1;
                chk(done === 1'b0, {tag, " R11 no extra done"}, 32'(done), 0);
            end
            chk(acc_n == n_exp, {tag, " R11 no extra access"}, acc_n, n_exp);
        end
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) regs[i] = $urandom;
        repeat (3) @(negedge clk);
        chk(!done && !err && !mem_req && !rf_we, "R1 reset outputs", {done, err, mem_req, rf_we}, 0);
        @(negedge clk); #1; rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!done && !err && !mem_req && !rf_we, "R1 after reset", {done, err, mem_req, rf_we}, 0);

        run_instr(4'd0, 2'd2, 5'd3, 5'd4, 32'h11, 32'h0, 0, "reg");
        run_instr(4'd1, 2'd0, 5'd3, 5'd4, 32'hdead_beef, 32'h0, 0, "imm");
        run_instr(4'd2, 2'd2, 5'd5, 5'd6, 32'h100, 32'h0, 0, "disp");
        run_instr(4'd3, 2'd1, 5'd7, 5'd6, 32'h0, 32'h0, 0, "rind");
        run_instr(4'd4, 2'd2, 5'd8, 5'd9, 32'h0, 32'h0, 0, "index");
        run_instr(4'd5, 2'd0, 5'd8, 5'd9, 32'h0, 32'h1001, 0, "abs");
        run_instr(4'd6, 2'd2, 5'd10, 5'd9, 32'h0, 32'h0, 0, "ptr");
        run_instr(4'd7, 2'd0, 5'd11, 5'd9, 32'h0, 32'h0, 0, "posti_b");
        run_instr(4'd7, 2'd2, 5'd11, 5'd9, 32'h0, 32'h0, 0, "posti_w");
        run_instr(4'd8, 2'd1, 5'd12, 5'd9, 32'h0, 32'h0, 0, "pred_h");
        run_instr(4'd8, 2'd2, 5'd12, 5'd9, 32'h0, 32'h0, 0, "pred_w");
        run_instr(4'd9, 2'd1, 5'd13, 5'd14, 32'h64, 32'h0, 0, "scale_h");
        run_instr(4'd9, 2'd2, 5'd13, 5'd13, 32'h64, 32'h0, 0, "scale_same");
        run_instr(4'd12, 2'd0, 5'd13, 5'd14, 32'h64, 32'h0, 0, "bad_mode");
        run_instr(4'd2, 2'd3, 5'd13, 5'd14, 32'h64, 32'h0, 0, "bad_size");
        run_instr(4'd7, 2'd2, 5'd15, 5'd1, 32'h0, 32'h0, 1, "busy_posti");
        run_instr(4'd6, 2'd0, 5'd16, 5'd1, 32'h0, 32'h0, 1, "busy_ptr");
        max_lat = 0;
        run_instr(4'd6, 2'd1, 5'd17, 5'd1, 32'h0, 32'h0, 0, "ptr_fast");
        max_lat = 9;
        run_instr(4'd6, 2'd1, 5'd17, 5'd1, 32'h0, 32'h0, 0, "ptr_slow");
        run_instr(4'd8, 2'd2, 5'd18, 5'd1, 32'h0, 32'h0, 0, "pred_slow");
        max_lat = 3;

        for (int n = 0; n < 120; n++) begin
            logic [3:0] rm;
            rm = ($urandom % 8 == 0) ? 4'($urandom) : 4'($urandom % 10);
            run_instr(rm, 2'($urandom % 4 == 0 ? $urandom : $urandom % 3), 5'($urandom), 5'($urandom),
                      $urandom, $urandom, ($urandom % 6 == 0) && rm >= 4'd2 && rm <= 4'd9, "rand");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule